// File: doc/BRIEF.md
# Charge Current Limit Ramp Generator

This block produces the digital reference code that a current-limit loop follows while a power switch charges a load's input capacitance. When a start pulse arrives, the reference begins at zero and climbs in equal steps, one step per timing tick, until it reaches the programmed charging-limit code after the programmed number of steps. It then holds that level. The gentle climb avoids sharp current steps that would pull the supply down through line inductance.

When the switch reports full enhancement (its drain-source drop has collapsed), the reference moves to the higher run-limit code used for steady overcurrent protection. An abort input returns the block to idle with a zero reference at any time. The charging limit, run limit and step count are captured when start is accepted, so the settings may change freely while a sequence runs. A phase output tells the surrounding control logic which part of the sequence is active.

Top module: `chg_ramp_gen`

## Requirements
- R1: While reset is low and on the first cycle after it, `ref_code` is 0 and `phase` is idle. Phase encoding: 0 idle, 1 ramp, 2 hold, 3 run.
- R2: A `start` pulse without `abort` makes `phase` ramp (1) and `ref_code` 0 on the following cycle.
- R3: With N = `rise_steps` (1 to 15), after k ticks of ramp (k < N) `ref_code` equals k multiplied by (charge code divided by N, integer division); cycles without a tick leave it unchanged.
- R4: On the N-th tick `ref_code` becomes exactly the charge code and `phase` becomes hold (2); during ramp `ref_code` never exceeds the charge code.
- R5: In hold, further ticks and idle cycles leave `ref_code` at the charge code and `phase` at hold.
- R6: `full_enh` in ramp or hold makes `ref_code` the run code and `phase` run (3) on the next cycle, and it takes priority over a tick in the same cycle; run then holds under ticks.
- R7: `full_enh` while idle is ignored: `ref_code` stays 0 and `phase` stays idle.
- R8: `abort` makes `ref_code` 0 and `phase` idle on the next cycle from any phase, and it wins over a simultaneous `start`.
- R9: The charge code, run code and step count are captured on the accepted `start`; changes on those inputs afterwards have no effect until the next start.
- R10: A `rise_steps` value of 0 is treated as one step: the first tick takes `ref_code` straight to the charge code.
- R11: A `start` during ramp, hold or run restarts the sequence from zero with freshly captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timing pulse that advances the ramp by one step |
| start | input | 1 | Begin a new charging sequence and capture the settings |
| abort | input | 1 | Return to idle with a zero reference |
| full_enh | input | 1 | Switch reports full enhancement |
| chg_code | input | CODE_W (8) | Charging-limit code |
| run_code | input | CODE_W (8) | Steady run-limit code |
| rise_steps | input | RISE_W (4) | Number of ramp steps (0 counts as 1) |
| ref_code | output | CODE_W (8) | Current-limit reference code |
| phase | output | 2 | Sequence phase: 0 idle, 1 ramp, 2 hold, 3 run |

## Verification
Every control input acts through one register stage, so each result of `start`, `tick`, `full_enh` and `abort` is due on the clock edge that samples it, and the bench drives inputs on the falling edge and compares both outputs on the following falling edge, one full cycle later. The expected reference is recomputed each cycle from the step count k since start using k times the integer quotient, with the exact charge code once k reaches the step count. Cycles without any pulse are inserted inside ramps to confirm that the reference advances only on ticks and not on clock cycles.

// File: rtl/chg_ramp_pkg.sv
// Shared types for the charge current limit ramp generator.
package chg_ramp_pkg;
    // Sequence phase; the encoding is visible on the phase output.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RAMP = 2'd1,
        PH_HOLD = 2'd2,
        PH_RUN  = 2'd3
    } phase_t;
endpackage

// File: rtl/ramp_cfg_hold.sv
// Captures the limit codes and step count on an accepted start and
// derives the per-step increment. Assumes RISE_W <= CODE_W. A step
// count of zero is stored as one.
module ramp_cfg_hold #(
    parameter int CODE_W = 8,
    parameter int RISE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] chg_in,
    input  logic [CODE_W-1:0] run_in,
    input  logic [RISE_W-1:0] rise_in,
    output logic [CODE_W-1:0] chg_q,
    output logic [CODE_W-1:0] run_q,
    output logic [RISE_W-1:0] steps_q,
    output logic [CODE_W-1:0] inc_q
);
    logic [RISE_W-1:0] steps_eff;
    logic [CODE_W-1:0] inc_d;

    // Force a zero step count to one and compute the step size.
    always_comb begin
        steps_eff = (rise_in == '0) ? RISE_W'(1) : rise_in;
        inc_d     = chg_in / CODE_W'(steps_eff);
    end

    // Hold the settings for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_q   <= '0;
            run_q   <= '0;
            steps_q <= RISE_W'(1);
            inc_q   <= '0;
        end else if (load) begin
            chg_q   <= chg_in;
            run_q   <= run_in;
            steps_q <= steps_eff;
            inc_q   <= inc_d;
        end
    end

    AST_STEPS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (steps_q != '0)); // R10
endmodule

// File: rtl/ramp_step_cnt.sv
// Counts ramp steps taken since start and flags the step that
// completes the ramp. Assumes steps is never zero and that advance
// is only raised while the count is below steps.
module ramp_step_cnt #(
    parameter int RISE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [RISE_W-1:0] steps,
    output logic              last
);
    logic [RISE_W-1:0] cnt_q;

    // The next step is the final one when count equals steps minus one.
    always_comb begin
        last = (cnt_q == (steps - RISE_W'(1)));
    end

    // Step counter, cleared on start or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + RISE_W'(1);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < steps); // R4
endmodule

// File: rtl/ramp_ref_reg.sv
// Holds the reference code. Priority: clear, then run load, then
// saturate to the charge code, then add one step.
module ramp_ref_reg #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_clr,
    input  logic              do_run,
    input  logic              do_sat,
    input  logic              do_add,
    input  logic [CODE_W-1:0] inc,
    input  logic [CODE_W-1:0] chg,
    input  logic [CODE_W-1:0] run,
    output logic [CODE_W-1:0] ref_q
);
    // Update the reference according to the selected operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (do_clr) begin
            ref_q <= '0;
        end else if (do_run) begin
            ref_q <= run;
        end else if (do_sat) begin
            ref_q <= chg;
        end else if (do_add) begin
            ref_q <= ref_q + inc;
        end
    end
endmodule

// File: rtl/chg_ramp_gen.sv
// Charge current limit ramp generator. On start, captures settings and
// ramps the reference from zero to the charge code in equal steps, one
// per tick, then holds; full enhancement switches to the run code.
// Abort returns to idle. Control priority: abort, start, full_enh, tick.
// Assumes tick, start, abort and full_enh are synchronous to clk.
module chg_ramp_gen
    import chg_ramp_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int RISE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              abort,
    input  logic              full_enh,
    input  logic [CODE_W-1:0] chg_code,
    input  logic [CODE_W-1:0] run_code,
    input  logic [RISE_W-1:0] rise_steps,
    output logic [CODE_W-1:0] ref_code,
    output logic [1:0]        phase
);
    phase_t            phase_q, phase_d;
    logic [CODE_W-1:0] chg_q, run_q, inc_q;
    logic [RISE_W-1:0] steps_q;
    logic              last;
    logic              restart, go_run, step, sat, add, active;

    // Decode the prioritised controls for this cycle.
    always_comb begin
        active  = (phase_q == PH_RAMP) || (phase_q == PH_HOLD);
        restart = start && !abort;
        go_run  = !abort && !start && full_enh && active;
        step    = !abort && !start && !full_enh && tick && (phase_q == PH_RAMP);
        sat     = step && last;
        add     = step && !last;
    end

    // Next phase.
    always_comb begin
        phase_d = phase_q;
        if (abort)        phase_d = PH_IDLE;
        else if (start)   phase_d = PH_RAMP;
        else if (go_run)  phase_d = PH_RUN;
        else if (sat)     phase_d = PH_HOLD;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    ramp_cfg_hold #(.CODE_W(CODE_W), .RISE_W(RISE_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (restart),
        .chg_in  (chg_code),
        .run_in  (run_code),
        .rise_in (rise_steps),
        .chg_q   (chg_q),
        .run_q   (run_q),
        .steps_q (steps_q),
        .inc_q   (inc_q)
    );

    ramp_step_cnt #(.RISE_W(RISE_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (abort || start),
        .advance (add),
        .steps   (steps_q),
        .last    (last)
    );

    ramp_ref_reg #(.CODE_W(CODE_W)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .do_clr (abort || start),
        .do_run (go_run),
        .do_sat (sat),
        .do_add (add),
        .inc    (inc_q),
        .chg    (chg_q),
        .run    (run_q),
        .ref_q  (ref_code)
    );

    assign phase = phase_q;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> (ref_code == '0)); // R1
    AST_START_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> (phase_q == PH_RAMP && ref_code == '0)); // R2
    AST_RAMP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RAMP && !abort && !start && !full_enh) |=> (ref_code >= $past(ref_code))); // R3
    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RAMP || phase_q == PH_HOLD) |-> (ref_code <= chg_q)); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD && !abort && !start && !full_enh) |=> ($stable(ref_code) && phase_q == PH_HOLD)); // R5
    AST_RUN_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RUN) |-> (ref_code == run_q)); // R6
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (phase_q == PH_IDLE && ref_code == '0)); // R8
endmodule

// File: tb/chg_ramp_gen_bench.sv
// Self-checking bench: sweeps charge codes and every step count, then
// directed sequences for run switch-over, abort, capture and restart.
module chg_ramp_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, start = 1'b0, abort = 1'b0, full_enh = 1'b0;
    logic [7:0] chg_code = '0, run_code = '0;
    logic [3:0] rise_steps = '0;
    logic [7:0] ref_code;
    logic [1:0] phase;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Bench model of the sequence, driven from the requirements.
    int m_chg = 0, m_run = 0, m_n = 1, m_k = 0, m_ph = 0;

    always #5 clk = ~clk;

    chg_ramp_gen u_chg_ramp_gen (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .abort(abort),
        .full_enh(full_enh), .chg_code(chg_code), .run_code(run_code),
        .rise_steps(rise_steps), .ref_code(ref_code), .phase(phase)
    );

    function automatic int exp_ref();
        case (m_ph)
            0: return 0;
            1: return m_k * (m_chg / m_n);
            2: return m_chg;
            default: return m_run;
        endcase
    endfunction

    task automatic check(input string tag);
        int er;
        er = exp_ref();
        vectors++;
        if (int'(ref_code) != er || int'(phase) != m_ph) begin
            errors++;
            $display("FAIL %s: ref=%0d phase=%0d expected ref=%0d phase=%0d",
                     tag, ref_code, phase, er, m_ph);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, then check a cycle later.
    task automatic apply(input string tag, input bit st, input bit ab,
                         input bit fe, input bit tk, input int c, input int r,
                         input int rs);
        start = st; abort = ab; full_enh = fe; tick = tk;
        chg_code = 8'(c); run_code = 8'(r); rise_steps = 4'(rs);
        @(negedge clk);
        start = 1'b0; abort = 1'b0; full_enh = 1'b0; tick = 1'b0;
        if (ab) begin
            m_ph = 0; m_k = 0;
        end else if (st) begin
            m_chg = c; m_run = r; m_n = (rs == 0) ? 1 : rs; m_k = 0; m_ph = 1;
        end else if (fe && (m_ph == 1 || m_ph == 2)) begin
            m_ph = 3;
        end else if (tk && m_ph == 1) begin
            m_k++;
            if (m_k >= m_n) m_ph = 2;
        end
        check(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: expired, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : stim
        int chg_list[6] = '{0, 1, 7, 100, 200, 255};
        repeat (3) @(negedge clk);
        check("R1");                            // in reset
        rst_n = 1'b1;
        check("R1");                            // first cycle after reset

        // Sweep charge codes over every step count.
        foreach (chg_list[i]) begin
            for (int rs = 0; rs < 16; rs++) begin
                apply("R2", 1, 0, 0, 0, chg_list[i], 50, rs);
                for (int t = 0; t < m_n + 2; t++) begin
                    if (t == 1) apply("R3", 0, 0, 0, 0, 0, 0, 0); // no tick
                    if (rs == 0)          apply("R10", 0, 0, 0, 1, 0, 0, 0);
                    else if (m_k + 1 < m_n) apply("R3", 0, 0, 0, 1, 0, 0, 0);
                    else if (m_k + 1 == m_n) apply("R4", 0, 0, 0, 1, 0, 0, 0);
                    else                  apply("R5", 0, 0, 0, 1, 0, 0, 0);
                end
                apply("R5", 0, 0, 0, 0, 0, 0, 0);
                apply("R6", 0, 0, 1, 0, 0, 0, 0);   // full enh in hold
                apply("R6", 0, 0, 0, 1, 0, 0, 0);   // tick in run
                apply("R8", 0, 1, 0, 0, 0, 0, 0);   // abort from run
            end
        end

        // R7: full enhancement while idle.
        apply("R7", 0, 0, 1, 0, 0, 0, 0);
        apply("R7", 0, 0, 1, 1, 0, 0, 0);

        // R9: settings change after start have no effect.
        apply("R2", 1, 0, 0, 0, 200, 50, 8);
        for (int t = 0; t < 5; t++) apply("R9", 0, 0, 0, 1, 3, 9, 1);
        apply("R6", 0, 0, 1, 1, 3, 9, 1);       // full wins over tick
        apply("R9", 0, 0, 0, 1, 77, 88, 2);
        apply("R6", 0, 0, 1, 0, 0, 0, 0);       // full in run: stays

        // R11: restart from run, hold and mid-ramp.
        apply("R11", 1, 0, 0, 0, 90, 120, 3);
        for (int t = 0; t < 3; t++) apply("R4", 0, 0, 0, 1, 0, 0, 0);
        apply("R11", 1, 0, 0, 0, 60, 30, 6);
        apply("R3", 0, 0, 0, 1, 0, 0, 0);
        apply("R3", 0, 0, 0, 1, 0, 0, 0);
        apply("R11", 1, 0, 0, 0, 45, 10, 5);
        apply("R3", 0, 0, 0, 1, 0, 0, 0);

        // R8: abort mid-ramp, abort with start, and abort from hold.
        apply("R8", 0, 1, 0, 1, 0, 0, 0);
        apply("R8", 0, 0, 0, 1, 0, 0, 0);
        apply("R8", 1, 1, 0, 0, 99, 99, 4);
        apply("R2", 1, 0, 0, 0, 33, 44, 1);
        apply("R4", 0, 0, 0, 1, 0, 0, 0);
        apply("R8", 0, 1, 1, 1, 0, 0, 0);

        // R6: switch-over from mid-ramp, then low run code is kept.
        apply("R2", 1, 0, 0, 0, 240, 5, 12);
        for (int t = 0; t < 4; t++) apply("R3", 0, 0, 0, 1, 0, 0, 0);
        apply("R6", 0, 0, 1, 0, 0, 0, 0);
        for (int t = 0; t < 3; t++) apply("R6", 0, 0, 0, 1, 0, 0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule